// File: doc/BRIEF.md
# Self-Synchronizing Idle-Locked Descrambler

This block undoes the stream-cipher scrambling applied to a 100 Mb/s twisted-pair Ethernet bit stream before NRZI decoding and code-group alignment. It takes recovered bits on a two-bit, valid-qualified interface. On that interface a clock cycle can carry no bit, one bit or two bits, because the receive front end drifts against the local clock.

The block finds the far end's keystream without any handshake. Between packets the transmitter sends idle, which is all ones before scrambling. While the block is unlocked, it treats every received bit as scrambled idle, shifts the implied keystream bit into its own 11-bit generator, and counts how many of its own predictions come true in a row. When enough predictions in a row are correct, it declares lock. From then on it XORs the predicted keystream with each received bit to recover the plain data.

Lock is kept only while a long run of idle keeps appearing in the descrambled stream. A bit counter measures the distance since the last such run, and lock is dropped when that distance reaches a byte limit that can be set by a parameter (for example, raised for jumbo frames). The output uses the same two-bit interface with one clock of latency, together with a lock flag. Output bits are not to be trusted while the flag is low.

Top module: `idle_lock_descrambler`

## Requirements
- R1: Input valid code 2'b00 carries no bit. Code 2'b01 carries one bit, on data bit 1. Codes 2'b10 and 2'b11 carry two bits, with data bit 0 the older and data bit 1 the newer. Bits are processed oldest first.
- R2: The output valid equals the input valid of the previous clock. Each output bit position carries the plain bit for the matching input position. An output position with no valid bit reads 0.
- R3: While unlocked, each received bit is inverted and shifted into the keystream generator. Each correct prediction increments a match count, and lock is declared on the bit that brings the count to LOCK_RUN (default 29). Lock therefore never comes in fewer than LOCK_RUN bits of idle, and always comes within LOCK_RUN+11 bits of idle.
- R4: Any wrong prediction while unlocked clears the match count.
- R5: While locked, each output bit equals the received bit XOR the keystream k[n] = k[n-11] XOR k[n-9], which is the sequence of the polynomial x^11 + x^9 + 1.
- R6: While locked, each bit advances a distance counter. The counter is cleared on every descrambled one that completes or extends a run of LOCK_RUN consecutive ones. Lock is lost, and the match count cleared, on the bit that brings the counter to TIMEOUT_BYTES*8.
- R7: A two-bit cycle gives the same plain bits and lock state as the same two bits delivered in two single-bit cycles.
- R8: A cycle with no valid bit leaves the keystream generator, lock state and counters unchanged.
- R9: After reset the block is unlocked, and the output valid and output bits are zero.
- R10: The lock flag output shows the lock state after all bits of the previous cycle have been processed, aligned with the output bits of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bits | input | 2 | Received scrambled bits; bit 1 is the newest |
| rx_vld | input | 2 | Valid code for rx_bits |
| plain_bits | output | 2 | Descrambled bits, same positions as the input |
| plain_vld | output | 2 | Valid code for plain_bits, one cycle after rx_vld |
| locked | output | 1 | High when the descrambled output is trustworthy |

## Verification
The bench checks that lock cannot be reached in 28 idle bits and is certainly reached by 40. A design that locked on a shorter run, or whose prediction used the wrong taps, would fail one of these two checks. It then sends a single plain zero after 25 idle bits, followed by 28 more idle bits. A design that did not clear the match count on the mismatch would lock too early there. The timeout is checked at the exact bit: 63 data bits after an idle run keep lock and the 64th drops it. Before that, 20 data bits followed by a run of ones must reset the distance, so a design that ignored the run would drop lock early. All of this runs under changing one-bit, two-bit and empty cycles, so a swapped slot order, a missed double step or state that moves on an empty cycle corrupts the compared plain bits.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // Keystream generator: x^11 + x^9 + 1. State bit 0 holds the newest bit.
  localparam int unsigned KS_LEN      = 11;
  localparam int unsigned KS_TAP_FAR  = 10;  // k[n-11]
  localparam int unsigned KS_TAP_NEAR = 8;   // k[n-9]

  // Lanes per clock on the bit interface.
  localparam int unsigned LANES = 2;

  typedef enum logic [1:0] {
    VC_NONE  = 2'b00,
    VC_ONE   = 2'b01,
    VC_TWO   = 2'b10,
    VC_TWO_B = 2'b11
  } vld_code_e;

  function automatic logic ks_predict(input logic [KS_LEN-1:0] st);
    return st[KS_TAP_FAR] ^ st[KS_TAP_NEAR];
  endfunction

endpackage

// File: rtl/dsc_slot_unpack.sv
module dsc_slot_unpack
  import dsc_pkg::*;
(
  input  logic [LANES-1:0] bits_i,
  input  logic [1:0]       vld_i,
  output logic [LANES-1:0] slot_en_o,   // slot 0 = older, processed first
  output logic [LANES-1:0] slot_bit_o
);

  always_comb begin
    slot_bit_o = bits_i;
    unique case (vld_code_e'(vld_i))
      VC_NONE:          slot_en_o = 2'b00;
      VC_ONE:           slot_en_o = 2'b10;
      VC_TWO, VC_TWO_B: slot_en_o = 2'b11;
      default:          slot_en_o = 2'b00;
    endcase
  end

endmodule

// File: rtl/dsc_bit_step.sv
module dsc_bit_step
  import dsc_pkg::*;
#(
  parameter int unsigned LOCK_RUN     = 29,
  parameter int unsigned TIMEOUT_BITS = 36000,
  parameter int unsigned MATCH_W      = $clog2(LOCK_RUN + 1),
  parameter int unsigned SINCE_W      = $clog2(TIMEOUT_BITS + 1)
) (
  input  logic               en_i,
  input  logic               bit_i,
  input  logic [KS_LEN-1:0]  ks_i,
  input  logic               locked_i,
  input  logic [MATCH_W-1:0] match_i,
  input  logic [MATCH_W-1:0] run_i,
  input  logic [SINCE_W-1:0] since_i,
  output logic [KS_LEN-1:0]  ks_o,
  output logic               locked_o,
  output logic [MATCH_W-1:0] match_o,
  output logic [MATCH_W-1:0] run_o,
  output logic [SINCE_W-1:0] since_o,
  output logic               plain_o
);

  localparam logic [MATCH_W:0] MATCH_LIM = (MATCH_W+1)'(LOCK_RUN);
  localparam logic [MATCH_W:0] RUN_LAST  = (MATCH_W+1)'(LOCK_RUN - 1);
  localparam logic [SINCE_W:0] SINCE_LIM = (SINCE_W+1)'(TIMEOUT_BITS);

  logic             pred;
  logic             inv_rx;
  logic [MATCH_W:0] match_inc;
  logic [MATCH_W:0] run_ext;
  logic [SINCE_W:0] since_inc;
  logic             idle_hit;

  always_comb begin
    pred      = ks_predict(ks_i);
    inv_rx    = ~bit_i;
    match_inc = {1'b0, match_i} + 1'b1;
    run_ext   = {1'b0, run_i};
    since_inc = {1'b0, since_i} + 1'b1;
    idle_hit  = 1'b0;

    ks_o     = ks_i;
    locked_o = locked_i;
    match_o  = match_i;
    run_o    = run_i;
    since_o  = since_i;
    plain_o  = 1'b0;

    if (en_i) begin
      plain_o = bit_i ^ pred;
      if (locked_i) begin
        ks_o     = {ks_i[KS_LEN-2:0], pred};
        idle_hit = plain_o && (run_ext >= RUN_LAST);
        if (!plain_o)      run_o = '0;
        else if (!idle_hit) run_o = run_i + 1'b1;
        if (idle_hit) begin
          since_o = '0;
        end else if (since_inc == SINCE_LIM) begin
          locked_o = 1'b0;
          match_o  = '0;
          run_o    = '0;
          since_o  = '0;
        end else begin
          since_o = since_inc[SINCE_W-1:0];
        end
      end else begin
        ks_o = {ks_i[KS_LEN-2:0], inv_rx};
        if (pred == inv_rx) begin
          if (match_inc == MATCH_LIM) begin
            locked_o = 1'b1;
            match_o  = '0;
            run_o    = '0;
            since_o  = '0;
          end else begin
            match_o = match_inc[MATCH_W-1:0];
          end
        end else begin
          match_o = '0;
        end
      end
    end
  end

endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler
  import dsc_pkg::*;
#(
  parameter int unsigned LOCK_RUN      = 29,
  parameter int unsigned TIMEOUT_BYTES = 4500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rx_bits,
  input  logic [1:0] rx_vld,
  output logic [1:0] plain_bits,
  output logic [1:0] plain_vld,
  output logic       locked
);

  localparam int unsigned TIMEOUT_BITS = TIMEOUT_BYTES * 8;
  localparam int unsigned MATCH_W      = $clog2(LOCK_RUN + 1);
  localparam int unsigned SINCE_W      = $clog2(TIMEOUT_BITS + 1);

  // Registered state
  logic [KS_LEN-1:0]  ks_q;
  logic               lock_q;
  logic [MATCH_W-1:0] match_q;
  logic [MATCH_W-1:0] run_q;
  logic [SINCE_W-1:0] since_q;

  logic [LANES-1:0] slot_en;
  logic [LANES-1:0] slot_bit;
  logic [LANES-1:0] slot_plain;

  // Chain links: index 0 is the registered state, index LANES the next state.
  logic [KS_LEN-1:0]  ch_ks    [0:LANES];
  logic               ch_lock  [0:LANES];
  logic [MATCH_W-1:0] ch_match [0:LANES];
  logic [MATCH_W-1:0] ch_run   [0:LANES];
  logic [SINCE_W-1:0] ch_since [0:LANES];

  dsc_slot_unpack u_unpack (
    .bits_i     (rx_bits),
    .vld_i      (rx_vld),
    .slot_en_o  (slot_en),
    .slot_bit_o (slot_bit)
  );

  assign ch_ks[0]    = ks_q;
  assign ch_lock[0]  = lock_q;
  assign ch_match[0] = match_q;
  assign ch_run[0]   = run_q;
  assign ch_since[0] = since_q;

  for (genvar g = 0; g < LANES; g++) begin : g_slot
    dsc_bit_step #(
      .LOCK_RUN     (LOCK_RUN),
      .TIMEOUT_BITS (TIMEOUT_BITS),
      .MATCH_W      (MATCH_W),
      .SINCE_W      (SINCE_W)
    ) u_step (
      .en_i     (slot_en[g]),
      .bit_i    (slot_bit[g]),
      .ks_i     (ch_ks[g]),
      .locked_i (ch_lock[g]),
      .match_i  (ch_match[g]),
      .run_i    (ch_run[g]),
      .since_i  (ch_since[g]),
      .ks_o     (ch_ks[g+1]),
      .locked_o (ch_lock[g+1]),
      .match_o  (ch_match[g+1]),
      .run_o    (ch_run[g+1]),
      .since_o  (ch_since[g+1]),
      .plain_o  (slot_plain[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_q       <= '0;
      lock_q     <= 1'b0;
      match_q    <= '0;
      run_q      <= '0;
      since_q    <= '0;
      plain_bits <= '0;
      plain_vld  <= '0;
    end else begin
      ks_q       <= ch_ks[LANES];
      lock_q     <= ch_lock[LANES];
      match_q    <= ch_match[LANES];
      run_q      <= ch_run[LANES];
      since_q    <= ch_since[LANES];
      plain_bits <= slot_plain & slot_en;
      plain_vld  <= rx_vld;
    end
  end

  assign locked = lock_q;

  // Output valid follows input valid by one clock.
  assert_valid_echo_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (plain_vld == $past(rx_vld)));

  // Empty positions read zero.
  assert_empty_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (plain_vld == 2'b00) |-> (plain_bits == 2'b00));

  // Match count stays below the lock threshold while hunting.
  assert_match_bound_R3: assert property (@(posedge clk) disable iff (rst)
    !lock_q |-> (match_q < MATCH_W'(LOCK_RUN)));

  // Distance counter never reaches the limit while locked.
  assert_since_bound_R6: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> (since_q < SINCE_W'(TIMEOUT_BITS)));

  // A lock drop leaves at most one fresh match behind (newer lane).
  assert_drop_clears_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> (match_q <= MATCH_W'(1)));

  // Empty cycles freeze the state.
  assert_hold_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_vld == 2'b00) |=> ($stable(ks_q) && $stable(lock_q) && $stable(since_q)));

endmodule

// File: tb/test_idle_lock_descrambler.sv
module test_idle_lock_descrambler;

  localparam int unsigned T_BYTES = 8;
  localparam int unsigned T_BITS  = T_BYTES * 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rx_bits = 2'b00;
  logic [1:0] rx_vld = 2'b00;
  logic [1:0] plain_bits;
  logic [1:0] plain_vld;
  logic       locked;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [10:0] sc = 11'h5A5;  // far-end keystream generator

  always #2 clk = ~clk;

  idle_lock_descrambler #(.LOCK_RUN(29), .TIMEOUT_BYTES(T_BYTES)) i_idle_lock_descrambler (
    .clk(clk), .rst(rst), .rx_bits(rx_bits), .rx_vld(rx_vld),
    .plain_bits(plain_bits), .plain_vld(plain_vld), .locked(locked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic key_next();
    logic k;
    k  = sc[10] ^ sc[8];
    sc = {sc[9:0], k};
    return k;
  endfunction

  // One clock: older/newer plain bits, scrambled and driven, then outputs checked.
  task automatic send(input logic [1:0] v, input logic p_old, input logic p_new, input bit chk);
    logic [1:0] c;
    logic [1:0] e;
    c = 2'b00;
    e = 2'b00;
    if (v[1]) begin
      c[0] = p_old ^ key_next();
      e[0] = p_old;
    end
    if (v != 2'b00) begin
      c[1] = p_new ^ key_next();
      e[1] = p_new;
    end
    @(negedge clk);
    rx_bits = c;
    rx_vld  = v;
    @(posedge clk);
    #1;
    check(plain_vld == v, "R2 valid echo", plain_vld, v);
    if (chk)
      check(plain_bits == e, "R1/R5/R7/R8 plain bits", plain_bits, e);
    else if (v != 2'b11 && v != 2'b10)
      check(plain_bits[0] == 1'b0, "R2 empty position", plain_bits[0], 0);
  endtask

  function automatic logic pat_bit(input bit idle, input int idx);
    return idle ? 1'b1 : ((idx % 3) != 0);
  endfunction

  // Stream n bits: idle or data pattern, single-bit or mixed 1/2/0/3 cycles.
  task automatic stream(input int n, input bit idle, input bit mixed, input bit chk);
    logic [1:0] codes [4];
    int idx;
    int cyc;
    logic [1:0] v;
    codes[0] = 2'b01; codes[1] = 2'b10; codes[2] = 2'b00; codes[3] = 2'b11;
    idx = 0;
    cyc = 0;
    while (idx < n) begin
      v = mixed ? codes[cyc % 4] : 2'b01;
      if (v[1] && (n - idx) < 2) v = 2'b01;
      if (v[1]) begin
        send(v, pat_bit(idle, idx), pat_bit(idle, idx + 1), chk);
        idx += 2;
      end else if (v == 2'b01) begin
        send(v, 1'b0, pat_bit(idle, idx), chk);
        idx += 1;
      end else begin
        send(v, 1'b0, 1'b0, chk);
      end
      cyc++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(locked == 1'b0, "R9 reset lock", locked, 0);
    check(plain_vld == 2'b00, "R9 reset valid", plain_vld, 0);
    check(plain_bits == 2'b00, "R9 reset bits", plain_bits, 0);
    @(negedge clk);
    rst = 1'b0;

    // R3: no lock within 28 idle bits, certain lock by 40.
    stream(28, 1'b1, 1'b0, 1'b0);
    check(locked == 1'b0, "R3 early lock after 28 bits", locked, 0);
    stream(12, 1'b1, 1'b0, 1'b0);
    check(locked == 1'b1, "R3 R10 lock after 40 bits", locked, 1);

    // Locked idle with mixed widths and empty cycles (R5 R7 R8).
    stream(40, 1'b1, 1'b1, 1'b1);
    check(locked == 1'b1, "R6 locked through idle", locked, 1);

    // R6: partial distance, then an idle run resets it.
    stream(20, 1'b0, 1'b1, 1'b1);
    stream(29, 1'b1, 1'b1, 1'b1);
    stream(T_BITS - 1, 1'b0, 1'b1, 1'b1);
    check(locked == 1'b1, "R6 lock kept one bit before limit", locked, 1);
    send(2'b01, 1'b0, 1'b0, 1'b1);
    check(locked == 1'b0, "R6 lock dropped at limit", locked, 0);

    // R4: a mismatch clears the match count.
    stream(25, 1'b1, 1'b0, 1'b0);
    check(locked == 1'b0, "R4 unlocked before mismatch", locked, 0);
    send(2'b01, 1'b0, 1'b0, 1'b0);
    stream(28, 1'b1, 1'b0, 1'b0);
    check(locked == 1'b0, "R4 count cleared by mismatch", locked, 0);
    stream(12, 1'b1, 1'b0, 1'b0);
    check(locked == 1'b1, "R3 relock after mismatch", locked, 1);

    // Data after relock, mixed widths (R5 R7 R8).
    stream(29, 1'b1, 1'b1, 1'b1);
    stream(40, 1'b0, 1'b1, 1'b1);
    check(locked == 1'b1, "R5 locked during data", locked, 1);

    // Empty cycles hold state (R8).
    send(2'b00, 1'b0, 1'b0, 1'b1);
    send(2'b00, 1'b0, 1'b0, 1'b1);
    stream(10, 1'b0, 1'b1, 1'b1);

    done = 1;
    summary();
    $finish;
  end

endmodule